// File: doc/BRIEF.md
# Error-Threshold Throttle State Controller

This block watches a set of per-event error flags and turns their recurrence into a flow-control status for the readout path. Every monitored condition owns a small leaky counter. Each accepted event moves that counter one step up if the condition is flagged, or one step down if it is not. Each condition also has a programmed threshold and a target status. When a flagged event finds the counter sitting exactly at the threshold, the condition asks for its target status.

The default configuration has twenty conditions: fifteen front-end header error bits, four event-number and bunch-number mismatch flags (normal and calibration triggers), and one bad orbit-marker spacing flag. The block does not generate these flags.

Once the status leaves READY it stays there, and can only move to a more severe status, until a resync pulse or reset clears every counter. A threshold of all ones (15) switches a condition off, whatever its target.

Top module: `err_throttle_ctrl`

## Requirements
- R1: After synchronous reset the status output is READY (4'b1000) and every counter is zero.
- R2: A counter changes only on a cycle with `evt_valid` high. It goes up by one when its condition bit is 1 and down by one when the bit is 0. Condition bits on cycles without an event are ignored.
- R3: Counters saturate at 0 and at 15 and never wrap.
- R4: A condition with threshold N (0..14) requests its target on the flagged event whose pre-event count equals N. That is the (N+1)-th flagged event counted up from zero.
- R5: Threshold 15 never requests a change, whatever the target code is.
- R6: Target code 0 (READY) never changes the status.
- R7: Target codes on `cfg_target` (3 bits per condition) are 0=READY, 1=WARNING, 2=BUSY, 3=OUT_OF_SYNC, 4=ERROR. They drive `status` as READY=1000, WARNING=0001, BUSY=0100, OUT_OF_SYNC=0010, ERROR=1100.
- R8: When several conditions fire in one event, the most severe target wins (ERROR > OUT_OF_SYNC > BUSY > WARNING). A held status is only replaced by a more severe one.
- R9: A non-READY status is held until `resync` is high. `resync` clears all counters, returns the status to READY, and overrides an event in the same cycle.
- R10: The status reflects an event at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Clears counters and status |
| evt_valid | input | 1 | One event is presented this cycle |
| cond_vec | input | NUM_COND | Condition flags for the event, bit i = condition i |
| cfg_thr | input | NUM_COND*4 | Threshold of condition i at bits [4i+3:4i] |
| cfg_target | input | NUM_COND*3 | Target code of condition i at bits [3i+2:3i] |
| status | output | 4 | Encoded throttle status |

## Verification
The counting rule is probed with several patterns. Runs of flagged events against thresholds 0 and 3 show that the trigger lands on exactly the (N+1)-th hit. Long runs of absent events followed by hits, and long runs of hits followed by a single absent event, separate saturation from wrap-around at both ends. Toggling flags without `evt_valid` shows that idle cycles do not count. Simultaneous multi-condition events and escalation over a held status separate the severity order from arrival order. A resync between two partial runs shows that counters really restart.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    typedef enum logic [2:0] {
        TGT_READY   = 3'd0,
        TGT_WARNING = 3'd1,
        TGT_BUSY    = 3'd2,
        TGT_OOS     = 3'd3,
        TGT_ERROR   = 3'd4
    } tgt_e;

    typedef struct packed {
        logic fire;
        tgt_e tgt;
    } req_t;

    localparam logic [3:0] CODE_READY   = 4'b1000;
    localparam logic [3:0] CODE_BUSY    = 4'b0100;
    localparam logic [3:0] CODE_OOS     = 4'b0010;
    localparam logic [3:0] CODE_WARNING = 4'b0001;
    localparam logic [3:0] CODE_ERROR   = 4'b1100;

    // Numeric order of tgt_e is the severity order.
    function automatic tgt_e worse_of(input tgt_e a, input tgt_e b);
        return (b > a) ? b : a;
    endfunction

    function automatic logic [3:0] encode_status(input tgt_e t);
        case (t)
            TGT_WARNING: return CODE_WARNING;
            TGT_BUSY:    return CODE_BUSY;
            TGT_OOS:     return CODE_OOS;
            TGT_ERROR:   return CODE_ERROR;
            default:     return CODE_READY;
        endcase
    endfunction

    // Unknown codes 5..7 are treated as READY (no effect).
    function automatic tgt_e decode_target(input logic [2:0] raw);
        return (raw > 3'd4) ? TGT_READY : tgt_e'(raw);
    endfunction

endpackage

// File: rtl/cond_counter.sv
module cond_counter
    import throttle_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic             cond,
    input  logic [CNT_W-1:0] thr,
    input  tgt_e             tgt,
    output req_t             req
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (evt) begin
            if (cond) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else begin
                if (cnt != '0) cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        req.fire = evt && cond && !clr && (thr != CNT_MAX) && (cnt == thr);
        req.tgt  = tgt;
    end

    p_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && evt && cond && !clr) |=> cnt == CNT_MAX);
    p_sat_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && evt && !cond) |=> cnt == '0);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> $stable(cnt));
    p_down_r2: assert property (@(posedge clk) disable iff (rst)
        (evt && !cond && !clr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    p_never_r5: assert property (@(posedge clk) disable iff (rst)
        (thr == CNT_MAX) |-> !req.fire);

endmodule

// File: rtl/severity_merge.sv
module severity_merge
    import throttle_pkg::*;
#(
    parameter int NUM_COND = 20
) (
    input  req_t [NUM_COND-1:0] reqs,
    output logic                any_fire,
    output tgt_e                worst
);
    always_comb begin
        any_fire = 1'b0;
        worst    = TGT_READY;
        for (int i = 0; i < NUM_COND; i++) begin
            if (reqs[i].fire) begin
                any_fire = 1'b1;
                worst    = worse_of(worst, reqs[i].tgt);
            end
        end
    end
endmodule

// File: rtl/status_hold.sv
module status_hold
    import throttle_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  tgt_e       new_tgt,
    output logic [3:0] code
);
    tgt_e cur;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cur <= TGT_READY;
        else if (upd)
            cur <= worse_of(cur, new_tgt);
    end

    assign code = encode_status(cur);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (code != CODE_READY && !clr) |=> code != CODE_READY);
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> code == CODE_READY);
    p_escalate_r8: assert property (@(posedge clk) disable iff (rst)
        (upd && !clr) |=> cur >= $past(new_tgt));
    p_legal_r7: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_READY || code == CODE_BUSY || code == CODE_OOS ||
         code == CODE_WARNING || code == CODE_ERROR));
endmodule

// File: rtl/err_throttle_ctrl.sv
module err_throttle_ctrl
    import throttle_pkg::*;
#(
    parameter int NUM_COND = 20,
    parameter int CNT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    resync,
    input  logic                    evt_valid,
    input  logic [NUM_COND-1:0]     cond_vec,
    input  logic [NUM_COND*4-1:0]   cfg_thr,
    input  logic [NUM_COND*3-1:0]   cfg_target,
    output logic [3:0]              status
);
    localparam int THR_W = 4;
    localparam int TGT_W = 3;

    req_t [NUM_COND-1:0] reqs;
    logic                any_fire;
    tgt_e                worst;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
        logic [CNT_W-1:0] thr_g;
        assign thr_g = cfg_thr[g*THR_W +: CNT_W];

        cond_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr  (resync),
            .evt  (evt_valid),
            .cond (cond_vec[g]),
            .thr  (thr_g),
            .tgt  (decode_target(cfg_target[g*TGT_W +: TGT_W])),
            .req  (reqs[g])
        );
    end

    severity_merge #(.NUM_COND(NUM_COND)) u_merge (
        .reqs     (reqs),
        .any_fire (any_fire),
        .worst    (worst)
    );

    status_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (resync),
        .upd     (any_fire),
        .new_tgt (worst),
        .code    (status)
    );

    p_reset_r1: assert property (@(posedge clk) rst |=> status == CODE_READY);
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (!evt_valid && !resync) |=> $stable(status));
endmodule

// File: tb/sim_err_throttle_ctrl.sv
module sim_err_throttle_ctrl;
    localparam int N = 20;

    logic           clk = 1'b0;
    logic           rst, resync, evt_valid;
    logic [N-1:0]   cond_vec;
    logic [N*4-1:0] cfg_thr;
    logic [N*3-1:0] cfg_target;
    logic [3:0]     status;

    logic [3:0] thr_a [N];
    logic [2:0] tgt_a [N];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_thr[i*4 +: 4]    = thr_a[i];
            cfg_target[i*3 +: 3] = tgt_a[i];
        end
    end

    err_throttle_ctrl #(.NUM_COND(N)) u0 (
        .clk(clk), .rst(rst), .resync(resync), .evt_valid(evt_valid),
        .cond_vec(cond_vec), .cfg_thr(cfg_thr), .cfg_target(cfg_target),
        .status(status)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    localparam logic [3:0] RDY = 4'b1000, BSY = 4'b0100, OOS = 4'b0010,
                           WRN = 4'b0001, ERR = 4'b1100;

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (status !== it.exp) begin
                errors++;
                $display("FAIL %s: status=%b expected=%b", it.tag, status, it.exp);
            end
        end
    end

    task automatic step(input logic ev, input logic rs, input logic [N-1:0] c,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        evt_valid = ev; resync = rs; cond_vec = c;
        @(posedge clk);
        #1;
        q.push_back('{exp, tag});
        evt_valid = 1'b0; resync = 1'b0;
    endtask

    task automatic do_resync(input string tag);
        step(1'b0, 1'b1, '0, RDY, tag);
    endtask

    task automatic cfg_default();
        for (int i = 0; i < N; i++) begin
            thr_a[i] = 4'd15; tgt_a[i] = 3'd0;
        end
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        cfg_default();
        rst = 1'b1; resync = 1'b0; evt_valid = 1'b0; cond_vec = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        q.push_back('{RDY, "R1 reset state"});

        // R5: defaults never throttle
        for (int k = 0; k < 20; k++) step(1, 0, '1, RDY, "R5 default thr15");
        do_resync("R9 resync");
        thr_a[3] = 4'd15; tgt_a[3] = 3'd4;
        for (int k = 0; k < 18; k++) step(1, 0, bit_of(3), RDY, "R5 thr15 target ERROR");
        cfg_default(); do_resync("R9 resync");

        // R4 / R7: threshold 0 -> first hit
        thr_a[0] = 4'd0; tgt_a[0] = 3'd1;
        step(1, 0, bit_of(0), WRN, "R4 R7 thr0 WARNING");
        do_resync("R9 clear to READY");

        // R2 idle cycles ignored, R4 threshold 3
        cfg_default(); thr_a[5] = 4'd3; tgt_a[5] = 3'd2;
        for (int k = 0; k < 10; k++) step(0, 0, bit_of(5), RDY, "R2 no event");
        for (int k = 0; k < 3; k++) step(1, 0, bit_of(5), RDY, "R4 below thr3");
        step(1, 0, bit_of(5), BSY, "R4 R7 fourth hit BUSY");
        for (int k = 0; k < 5; k++) step(1, 0, '0, BSY, "R9 held BUSY");
        step(0, 0, '0, BSY, "R10 idle stable");
        do_resync("R9 resync");

        // R3 floor: saturate at 0
        cfg_default(); thr_a[7] = 4'd2; tgt_a[7] = 3'd1;
        for (int k = 0; k < 5; k++) step(1, 0, '0, RDY, "R3 absent at floor");
        step(1, 0, bit_of(7), RDY, "R3 hit1");
        step(1, 0, bit_of(7), RDY, "R3 hit2");
        step(1, 0, bit_of(7), WRN, "R3 R4 hit3 after floor");
        do_resync("R9 resync");

        // R3 ceiling: saturate at 15
        cfg_default();
        for (int k = 0; k < 20; k++) step(1, 0, bit_of(9), RDY, "R3 climb disabled");
        thr_a[9] = 4'd14; tgt_a[9] = 3'd2;
        for (int k = 0; k < 12; k++) step(1, 0, bit_of(9), RDY, "R3 pinned at 15");
        step(1, 0, '0, RDY, "R3 step down");
        step(1, 0, bit_of(9), BSY, "R3 R4 refire at 14");
        do_resync("R9 resync");

        // R8 severity among simultaneous
        cfg_default();
        thr_a[1] = 0; tgt_a[1] = 3'd1;
        thr_a[2] = 0; tgt_a[2] = 3'd4;
        thr_a[4] = 0; tgt_a[4] = 3'd3;
        thr_a[6] = 0; tgt_a[6] = 3'd2;
        step(1, 0, bit_of(1) | bit_of(2) | bit_of(4), ERR, "R8 ERROR wins");
        do_resync("R9 resync");
        step(1, 0, bit_of(1) | bit_of(4), OOS, "R8 R7 OOS over WARNING");
        do_resync("R9 resync");
        step(1, 0, bit_of(1), WRN, "R8 first WARNING");
        step(1, 0, bit_of(6), BSY, "R8 escalate to BUSY");
        step(1, 0, bit_of(2), ERR, "R8 escalate to ERROR");
        do_resync("R9 resync");
        step(1, 0, bit_of(2), ERR, "R8 ERROR held");
        step(1, 0, bit_of(6), ERR, "R8 no downgrade");
        do_resync("R9 resync");

        // R6 target READY
        cfg_default(); thr_a[8] = 0; tgt_a[8] = 3'd0;
        step(1, 0, bit_of(8), RDY, "R6 READY target");
        step(1, 0, bit_of(8), RDY, "R6 READY target again");

        // R9 resync overrides event, and clears counters
        thr_a[2] = 0; tgt_a[2] = 3'd4;
        step(1, 1, bit_of(2), RDY, "R9 resync beats event");
        thr_a[2] = 4'd15;
        thr_a[5] = 4'd3; tgt_a[5] = 3'd2;
        step(1, 0, bit_of(5), RDY, "R9 partial1");
        step(1, 0, bit_of(5), RDY, "R9 partial2");
        do_resync("R9 resync mid-run");
        step(1, 0, bit_of(5), RDY, "R9 restart1");
        step(1, 0, bit_of(5), RDY, "R9 restart2");
        step(1, 0, bit_of(5), RDY, "R9 restart3");
        step(1, 0, bit_of(5), BSY, "R9 R4 restart4 fires");

        // R1 reset returns READY
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        q.push_back('{RDY, "R1 reset clears status"});

        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule